// File: doc/BRIEF.md
# Radio Power-Mode Sequencer

This controller runs on a 1 MHz clock, so one cycle is 1 µs. It decides which parts of a short-range radio transceiver have power. The baseband drives four pins: a power request, an oscillator enable, a data line and a packet-control line. The controller reads these pins together with two enables that come from the configuration registers, one for receive and one for transmit. From them it moves the radio through its states: off, oscillator start-up, idle, sleep, transmit (settle, sync, PA on, run, PA off) and receive (settle, run). The oscillator-settled flag is an input.

Every input passes through a two-flop synchronizer before it is decoded. The controller detects edges on the synchronized values. It drives five power controls: oscillator power, reset release, TX path power, PA power and RX path power. Each control is decoded from the state and from a single settle counter. When the controller sees an input combination it does not define, the state stays where it is.

Top module: `radio_pwr_fsm`

## Requirements
- R1: While `rst_n` is low, or from the third rising clock edge after `pwr_req` goes low, all five outputs are 0.
- R2: After `pwr_req` goes high, `osc_pwr` is 1 and `rst_rel` stays 0. `rst_rel` rises only once `osc_ok` has been seen high and then `osc_en` has been seen high. TX, PA and RX power are never on without both `osc_pwr` and `rst_rel`.
- R3: An input change takes effect at the third rising edge after it is applied: two synchronizer stages plus the state register.
- R4: In idle, a rising `tx_en` while `rx_en` is low starts TX settling. `tx_pwr` rises exactly `SYN_DLY` cycles after the state changes, which is at edge 3+`SYN_DLY` after `tx_en` is applied.
- R5: After TX power is on, a rising `bb_data` while `pkt_ctl` is low enters data sync. A later rising `pkt_ctl` turns `pa_pwr` on at the third edge. `pa_pwr` is never on without `tx_pwr`.
- R6: A falling `pkt_ctl` during transmit drops `pa_pwr` first. `tx_pwr` drops exactly one cycle later.
- R7: A falling `tx_en` returns the machine to idle from TX settling, and from PA-off once TX power is off.
- R8: In idle, a rising `rx_en` while `tx_en` is low brings `rx_pwr` on at edge 3+`SYN_DLY`. A falling `rx_en` clears `rx_pwr` and returns to idle. `rx_pwr` and `tx_pwr` are never both 1.
- R9: If `rx_en` is high when idle is entered from PA-off, the machine spends one cycle in idle and then starts RX settling. `rx_pwr` then rises at edge 4+`SYN_DLY` after `tx_en` falls.
- R10: The following requests are ignored, and the power outputs do not change:
  - `tx_en` and `rx_en` rising together in idle;
  - a `bb_data` rise before TX power is on;
  - a `pkt_ctl` rise before data sync;
  - `tx_en` rising during receive.
- R11: In idle, `osc_en` low enters sleep: `osc_pwr` goes to 0 and `rst_rel` stays 1. `osc_en` high leaves sleep with `osc_pwr` back on, but the machine returns to idle only after `osc_ok` is high. Until then, TX requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Baseband power request |
| osc_en | input | 1 | Baseband oscillator enable |
| bb_data | input | 1 | Baseband data line |
| pkt_ctl | input | 1 | Baseband packet control |
| rx_en | input | 1 | Register receive enable |
| tx_en | input | 1 | Register transmit enable |
| osc_ok | input | 1 | Oscillator settled flag |
| osc_pwr | output | 1 | Oscillator power |
| rst_rel | output | 1 | Reset release (configuration kept) |
| tx_pwr | output | 1 | TX path and synthesizer power |
| pa_pwr | output | 1 | Power amplifier power |
| rx_pwr | output | 1 | RX path power |

## Verification
The bench counts the exact edge on which TX and RX power come on, both from idle and through the deferred receive path. A counter that is off by one, or that skips the extra idle cycle, shows up as a shifted count. The bench checks the PA-off ordering cycle by cycle. A design that drops PA and TX together, or drops TX first, fails that check. It sends the illegal requests (both enables together, data before TX is ready, packet control before sync, TX during receive) and checks that no power output moves. The sleep exit is held with `osc_ok` low, which catches a machine that goes straight back to idle.

// File: rtl/radio_pwr_fsm.sv
module radio_pwr_fsm #(
  parameter int SYN_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic osc_en,
  input  logic bb_data,
  input  logic pkt_ctl,
  input  logic rx_en,
  input  logic tx_en,
  input  logic osc_ok,
  output logic osc_pwr,
  output logic rst_rel,
  output logic tx_pwr,
  output logic pa_pwr,
  output logic rx_pwr
);
  localparam int CW = $clog2(SYN_DLY + 1);
  localparam logic [CW-1:0] CMAX = CW'(SYN_DLY);

  typedef enum logic [3:0] {
    S_OFF, S_XO_START, S_XO_HOLD, S_IDLE, S_SLEEP, S_XO_WAKE,
    S_TX_SETTLE, S_TX_SYNC, S_PA_ON, S_TX_RUN, S_PA_OFF,
    S_RX_SETTLE, S_RX_RUN
  } st_t;

  st_t st, nxt;
  logic [6:0] s1, s2, pv;
  logic [CW-1:0] cnt;
  logic defer;

  wire [6:0] raw = {pwr_req, osc_en, bb_data, pkt_ctl, rx_en, tx_en, osc_ok};
  wire [6:0] up = s2 & ~pv;
  wire [6:0] dn = ~s2 & pv;
  wire pwr_s = s2[6];
  wire osc_s = s2[5];
  wire pkt_s = s2[3];
  wire rx_s  = s2[2];
  wire tx_s  = s2[1];
  wire ok_s  = s2[0];
  wire ready = (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      pv <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      pv <= s2;
    end
  end

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:       if (pwr_s) nxt = S_XO_START;
      S_XO_START:  if (ok_s) nxt = S_XO_HOLD;
      S_XO_HOLD:   if (osc_s) nxt = S_IDLE;
      S_IDLE: begin
        if (!osc_s) nxt = S_SLEEP;
        else if (defer) begin
          if (rx_s) nxt = S_RX_SETTLE;
        end
        else if (up[1] && !rx_s) nxt = S_TX_SETTLE;
        else if (up[2] && !tx_s) nxt = S_RX_SETTLE;
      end
      S_SLEEP:     if (osc_s) nxt = S_XO_WAKE;
      S_XO_WAKE:   if (ok_s) nxt = S_IDLE;
      S_TX_SETTLE: begin
        if (!tx_s) nxt = S_IDLE;
        else if (ready && up[4] && !pkt_s) nxt = S_TX_SYNC;
      end
      S_TX_SYNC:   if (up[3]) nxt = S_PA_ON;
      S_PA_ON:     nxt = S_TX_RUN;
      S_TX_RUN:    if (dn[3]) nxt = S_PA_OFF;
      S_PA_OFF:    if (!tx_s && cnt != '0) nxt = S_IDLE;
      S_RX_SETTLE: begin
        if (!rx_s) nxt = S_IDLE;
        else if (ready) nxt = S_RX_RUN;
      end
      S_RX_RUN:    if (!rx_s) nxt = S_IDLE;
      default:     nxt = S_OFF;
    endcase
    if (!pwr_s) nxt = S_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      defer <= 1'b0;
    end else begin
      st    <= nxt;
      defer <= (st == S_PA_OFF) && (nxt == S_IDLE) && rx_s;
      if (nxt != st) cnt <= '0;
      else if (!ready) cnt <= cnt + 1'b1;
    end
  end

  assign osc_pwr = (st != S_OFF) && (st != S_SLEEP);
  assign rst_rel = (st != S_OFF) && (st != S_XO_START) && (st != S_XO_HOLD);
  assign pa_pwr  = (st == S_PA_ON) || (st == S_TX_RUN);
  assign tx_pwr  = ((st == S_TX_SETTLE) && ready) || (st == S_TX_SYNC) || pa_pwr ||
                   ((st == S_PA_OFF) && (cnt == '0));
  assign rx_pwr  = ((st == S_RX_SETTLE) && ready) || (st == S_RX_RUN);
endmodule

// File: rtl/radio_pwr_fsm_chk.sv
module radio_pwr_fsm_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_s,
  input logic osc_pwr,
  input logic rst_rel,
  input logic tx_pwr,
  input logic pa_pwr,
  input logic rx_pwr
);
  // R1
  off_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> !(osc_pwr || rst_rel || tx_pwr || pa_pwr || rx_pwr));

  // R2
  pwr_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pwr || rx_pwr || pa_pwr) |-> (osc_pwr && rst_rel));

  // R5
  pa_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_pwr |-> tx_pwr);

  // R6
  pa_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pa_pwr) && $past(pwr_s)) |-> tx_pwr);

  // R6
  tx_off_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pa_pwr) && $past(pwr_s)) |=> !tx_pwr);

  // R8
  rx_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_pwr && tx_pwr));
endmodule

bind radio_pwr_fsm radio_pwr_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_s(pwr_s), .osc_pwr(osc_pwr),
  .rst_rel(rst_rel), .tx_pwr(tx_pwr), .pa_pwr(pa_pwr), .rx_pwr(rx_pwr)
);

// File: tb/tb_radio_pwr_fsm.sv
module tb_radio_pwr_fsm;
  localparam int CLK_P = 10;
  localparam int SYN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 0, osc_en = 0, bb_data = 0, pkt_ctl = 0;
  logic rx_en = 0, tx_en = 0, osc_ok = 0;
  logic osc_pwr, rst_rel, tx_pwr, pa_pwr, rx_pwr;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  radio_pwr_fsm #(.SYN_DLY(SYN)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .osc_en(osc_en),
    .bb_data(bb_data), .pkt_ctl(pkt_ctl), .rx_en(rx_en), .tx_en(tx_en),
    .osc_ok(osc_ok), .osc_pwr(osc_pwr), .rst_rel(rst_rel),
    .tx_pwr(tx_pwr), .pa_pwr(pa_pwr), .rx_pwr(rx_pwr)
  );

  wire [4:0] o = {osc_pwr, rst_rel, tx_pwr, pa_pwr, rx_pwr};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    total++;
    if (o !== exp) begin
      bad++;
      $display("FAIL %s outputs got=%b exp=%b", req, o, exp);
    end
  endtask

  task automatic lat(input string req, input int idx, input int exp);
    int n = 0;
    while (o[idx] !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (n != exp) begin
      bad++;
      $display("FAIL %s latency got=%0d exp=%0d", req, n, exp);
    end
  endtask

  task automatic tx_to_run(input int hold);
    tx_en = 1;
    lat("R4", 2, 3 + SYN);
    chk("R4", 5'b11100);
    bb_data = 1;
    tick(3);
    chk("R5", 5'b11100);
    pkt_ctl = 1;
    tick(2);
    chk("R5", 5'b11100);
    tick(1);
    chk("R5", 5'b11110);
    for (int k = 0; k < hold; k++) begin
      bb_data = ~bb_data;
      tick(1);
    end
    bb_data = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1", 5'b00000);
    rst_n = 1;
    tick(5);
    chk("R1", 5'b00000);

    pwr_req = 1;
    tick(2);
    chk("R3", 5'b00000);
    tick(1);
    chk("R2", 5'b10000);
    tick(10);
    chk("R2", 5'b10000);
    osc_ok = 1;
    tick(5);
    chk("R2", 5'b10000);
    osc_en = 1;
    tick(2);
    chk("R3", 5'b10000);
    tick(1);
    chk("R2", 5'b11000);

    for (int i = 0; i < 3; i++) begin
      tx_to_run(i + 2);
      pkt_ctl = 0;
      tick(3);
      chk("R6", 5'b11100);
      tick(1);
      chk("R6", 5'b11000);
      tick(i);
      tx_en = 0;
      tick(4);
      chk("R7", 5'b11000);
    end

    rx_en = 1;
    lat("R8", 0, 3 + SYN);
    chk("R8", 5'b11001);
    tx_en = 1;
    tick(6);
    chk("R10", 5'b11001);
    tx_en = 0;
    tick(3);
    rx_en = 0;
    tick(3);
    chk("R8", 5'b11000);

    tx_en = 1;
    rx_en = 1;
    tick(3 + SYN + 3);
    chk("R10", 5'b11000);
    tx_en = 0;
    rx_en = 0;
    tick(4);

    tx_to_run(2);
    rx_en = 1;
    tick(4);
    chk("R9", 5'b11110);
    pkt_ctl = 0;
    tick(5);
    chk("R6", 5'b11000);
    tx_en = 0;
    lat("R9", 0, 4 + SYN);
    chk("R9", 5'b11001);
    rx_en = 0;
    tick(3);
    chk("R8", 5'b11000);

    tx_en = 1;
    tick(3);
    bb_data = 1;
    tick(SYN + 3);
    chk("R10", 5'b11100);
    pkt_ctl = 1;
    tick(5);
    chk("R10", 5'b11100);
    pkt_ctl = 0;
    bb_data = 0;
    tick(2);
    tx_en = 0;
    tick(3);
    chk("R7", 5'b11000);

    osc_ok = 0;
    osc_en = 0;
    tick(2);
    chk("R11", 5'b11000);
    tick(1);
    chk("R11", 5'b01000);
    tx_en = 1;
    tick(5);
    chk("R11", 5'b01000);
    tx_en = 0;
    tick(3);
    osc_en = 1;
    tick(3);
    chk("R11", 5'b11000);
    tx_en = 1;
    tick(3 + SYN + 2);
    chk("R11", 5'b11000);
    tx_en = 0;
    tick(3);
    osc_ok = 1;
    tick(3);
    tx_en = 1;
    lat("R11", 2, 3 + SYN);

    pwr_req = 0;
    tick(2);
    chk("R3", 5'b11100);
    tick(1);
    chk("R1", 5'b00000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule